// File: doc/BRIEF.md
# Processor control register file

This block holds the four 32-bit control registers of a small protected-mode processor model. Slot 0 is the mode and status word, slot 1 is reserved, slot 2 records the linear address of a faulting access, and slot 3 holds the page-directory base. Software reaches the registers through one write port and one read port. The write port is accepted on every clock edge where `wr_en` is high. The read port is combinational on the current register state. Neither port has a valid/ready handshake or back-pressure, because every access completes in a single cycle.

Hardware events also change register bits. A task-switch pulse sets the task-switched flag. A page-fault pulse loads the faulting address. A decode strobe marks each coprocessor (escape) instruction. The block checks that strobe against the emulate and task-switched flags. When either flag is set, it raises a vector-7 "coprocessor not available" request in the same cycle. The protection-enable and paging-enable bits are driven out directly as mode pins.

Top module: `cpu_ctl_regs`

## Requirements
- R1: A synchronous reset (`rst_n` low at a clock edge) clears every register. After reset, every slot reads 0 and `prot_en`, `paging_en` and `cop_unavail` are 0.
- R2: Slot 0 stores only these bits:
  - bit 0: protection enable
  - bit 1: math present
  - bit 2: emulate
  - bit 3: task switched
  - bit 4: coprocessor type
  - bit 31: paging enable

  All other bits read 0. For example, writing 0xFFFFFFFF reads back 0x8000001F. `prot_en` follows bit 0 and `paging_en` follows bit 31.
- R3: Slot 1 always reads 0, and a write to it changes no register.
- R4: Slot 3 stores bits 31..12 of a write, and bits 11..0 always read 0. For example, writing 0x12345ABC reads back 0x12345000.
- R5: A one-cycle `page_fault` pulse loads `fault_lin_addr` into slot 2, readable on the following cycle. Software may also write slot 2.
- R6: A `task_switch` pulse sets bit 3 of slot 0, with no other bit changed.
- R7: While bit 3 of slot 0 is 1, `cop_unavail` is high in exactly the cycles where `esc_strobe` is high.
- R8: While bit 2 of slot 0 is 1, `cop_unavail` is high in every cycle where `esc_strobe` is high, whatever bit 3 holds. When bits 2 and 3 are both 0, `cop_unavail` stays low.
- R9: Software can clear bit 0 of slot 0 by writing 0, which drops `prot_en` to 0.
- R10: When a write and an event occur in the same cycle, the event wins for the bits it affects:
  - A slot 0 write together with `task_switch` keeps the written bits but sets bit 3.
  - A slot 2 write together with `page_fault` stores `fault_lin_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 2 | Slot written |
| wr_data | input | 32 | Write value |
| rd_idx | input | 2 | Slot read |
| rd_data | output | 32 | Read value of slot `rd_idx` |
| task_switch | input | 1 | Task-switch event pulse |
| page_fault | input | 1 | Page-fault event pulse |
| fault_lin_addr | input | 32 | Linear address of the faulting access |
| esc_strobe | input | 1 | Coprocessor instruction decoded this cycle |
| prot_en | output | 1 | Protected mode enabled |
| paging_en | output | 1 | Page translation enabled |
| cop_unavail | output | 1 | Vector-7 exception request, one cycle per strobe |

## Verification
The test writes all ones to each slot, which shows which bits each slot keeps and confirms that the reserved slot absorbs writes. It then drives the escape strobe under four flag states: both flags clear, emulate only, task-switched only, and both set. These separate the two trap causes from each other and from the no-trap case. Strobe-low cycles in between show that the request is a pulse. Writes are issued in the same cycle as task-switch and page-fault events, which shows that the event wins only on the bits it touches. Finally, slot 0 is written back to zero, which confirms that protected mode can be left again.

// File: rtl/ctl_regs_pkg.sv
package ctl_regs_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned IDX_W      = 2;
  localparam int unsigned PAGE_SHIFT = 12;

  // bit positions inside the mode and status word
  localparam int unsigned B_PE = 0;
  localparam int unsigned B_MP = 1;
  localparam int unsigned B_EM = 2;
  localparam int unsigned B_TS = 3;
  localparam int unsigned B_ET = 4;
  localparam int unsigned B_PG = 31;

  typedef enum logic [IDX_W-1:0] {
    SLOT_MODE  = 2'd0,
    SLOT_RSVD  = 2'd1,
    SLOT_FAULT = 2'd2,
    SLOT_PDIR  = 2'd3
  } slot_e;

  typedef struct packed {
    logic pg;
    logic et;
    logic ts;
    logic em;
    logic mp;
    logic pe;
  } mode_t;
endpackage

// File: rtl/mode_word.sv
module mode_word
  import ctl_regs_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          task_switch,
  output mode_t         mode,
  output logic [DW-1:0] word
);
  mode_t mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else begin
      if (wr) begin
        mode_q.pe <= wdata[B_PE];
        mode_q.mp <= wdata[B_MP];
        mode_q.em <= wdata[B_EM];
        mode_q.ts <= wdata[B_TS];
        mode_q.et <= wdata[B_ET];
        mode_q.pg <= wdata[B_PG];
      end
      if (task_switch) mode_q.ts <= 1'b1;
    end
  end

  always_comb begin
    word       = '0;
    word[B_PE] = mode_q.pe;
    word[B_MP] = mode_q.mp;
    word[B_EM] = mode_q.em;
    word[B_TS] = mode_q.ts;
    word[B_ET] = mode_q.et;
    word[B_PG] = mode_q.pg;
  end

  assign mode = mode_q;

  // R6
  ts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    task_switch |=> mode_q.ts);
endmodule

// File: rtl/fault_addr_reg.sv
module fault_addr_reg #(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          page_fault,
  input  logic [DW-1:0] fault_lin_addr,
  output logic [DW-1:0] value
);
  logic [DW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          addr_q <= '0;
    else if (page_fault) addr_q <= fault_lin_addr;
    else if (wr)         addr_q <= wdata;
  end

  assign value = addr_q;

  // R5
  fault_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_fault |=> (addr_q == $past(fault_lin_addr)));
endmodule

// File: rtl/pdir_base_reg.sv
module pdir_base_reg #(
  parameter int unsigned DW    = 32,
  parameter int unsigned SHIFT = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] value
);
  localparam int unsigned HI_W = DW - SHIFT;
  logic [HI_W-1:0] base_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  base_q <= '0;
    else if (wr) base_q <= wdata[DW-1:SHIFT];
  end

  assign value = {base_q, {SHIFT{1'b0}}};
endmodule

// File: rtl/copro_guard.sv
module copro_guard (
  input  logic esc_strobe,
  input  logic ts,
  input  logic em,
  output logic req
);
  always_comb req = esc_strobe && (ts || em);
endmodule

// File: rtl/cpu_ctl_regs.sv
module cpu_ctl_regs
  import ctl_regs_pkg::*;
#(
  parameter int unsigned DW = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data,
  input  logic             task_switch,
  input  logic             page_fault,
  input  logic [DW-1:0]    fault_lin_addr,
  input  logic             esc_strobe,
  output logic             prot_en,
  output logic             paging_en,
  output logic             cop_unavail
);
  mode_t         mode;
  logic [DW-1:0] mode_val, fault_val, pdir_val;

  logic wr_mode, wr_fault, wr_pdir;
  assign wr_mode  = wr_en && (slot_e'(wr_idx) == SLOT_MODE);
  assign wr_fault = wr_en && (slot_e'(wr_idx) == SLOT_FAULT);
  assign wr_pdir  = wr_en && (slot_e'(wr_idx) == SLOT_PDIR);

  mode_word #(.DW(DW)) u_mode (
    .clk(clk), .rst_n(rst_n), .wr(wr_mode), .wdata(wr_data),
    .task_switch(task_switch), .mode(mode), .word(mode_val)
  );

  fault_addr_reg #(.DW(DW)) u_fault (
    .clk(clk), .rst_n(rst_n), .wr(wr_fault), .wdata(wr_data),
    .page_fault(page_fault), .fault_lin_addr(fault_lin_addr), .value(fault_val)
  );

  pdir_base_reg #(.DW(DW), .SHIFT(PAGE_SHIFT)) u_pdir (
    .clk(clk), .rst_n(rst_n), .wr(wr_pdir), .wdata(wr_data), .value(pdir_val)
  );

  copro_guard u_guard (
    .esc_strobe(esc_strobe), .ts(mode.ts), .em(mode.em), .req(cop_unavail)
  );

  always_comb begin
    unique case (slot_e'(rd_idx))
      SLOT_MODE:  rd_data = mode_val;
      SLOT_FAULT: rd_data = fault_val;
      SLOT_PDIR:  rd_data = pdir_val;
      default:    rd_data = '0;
    endcase
  end

  assign prot_en   = mode.pe;
  assign paging_en = mode.pg;

  // R3
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_e'(rd_idx) == SLOT_RSVD) |-> (rd_data == '0));

  // R4
  pdir_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_e'(rd_idx) == SLOT_PDIR) |-> (rd_data[PAGE_SHIFT-1:0] == '0));

  // R7
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !esc_strobe |-> !cop_unavail);

  // R8
  em_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (esc_strobe && (slot_e'(rd_idx) == SLOT_MODE) && rd_data[B_EM]) |-> cop_unavail);
endmodule

// File: tb/sim_cpu_ctl_regs.sv
module sim_cpu_ctl_regs;
  localparam int CLK_PERIOD = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_idx = '0;
  logic [31:0] rd_data;
  logic        task_switch = 1'b0;
  logic        page_fault = 1'b0;
  logic [31:0] fault_lin_addr = '0;
  logic        esc_strobe = 1'b0;
  logic        prot_en, paging_en, cop_unavail;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    int          kind;   // 0..3 slot read, 4 = {prot_en,paging_en,cop_unavail}
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];
  event  ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_ctl_regs u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .task_switch(task_switch),
    .page_fault(page_fault), .fault_lin_addr(fault_lin_addr),
    .esc_strobe(esc_strobe), .prot_en(prot_en), .paging_en(paging_en),
    .cop_unavail(cop_unavail)
  );

  // monitor: pops the scoreboard and compares with the ports
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      @(ev);
      it = sb.pop_front();
      act = (it.kind < 4) ? rd_data : {29'b0, prot_en, paging_en, cop_unavail};
      tests++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(int kind, logic [31:0] exp, string tag);
    item_t it;
    if (kind < 4) rd_idx = kind[1:0];
    #1;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sb.push_back(it);
    -> ev;
    #1;
  endtask

  task automatic wr(logic [1:0] idx, logic [31:0] d);
    wr_en = 1'b1; wr_idx = idx; wr_data = d;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
  endtask

  task automatic check_all_zero(string tag);
    for (int i = 0; i < 4; i++) push(i, 32'h0, tag);
    push(4, 32'h0, tag);
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    check_all_zero("R1 reset");

    wr(2'd0, 32'hFFFF_FFFF);
    push(0, 32'h8000_001F, "R2 mode word mask");
    push(4, 32'h6, "R2 mode pins");
    esc_strobe = 1'b1;
    push(4, 32'h7, "R7 trap with both flags");
    esc_strobe = 1'b0;
    push(4, 32'h6, "R7 pulse ends with strobe");

    wr(2'd0, 32'h0);
    push(0, 32'h0, "R9 clear mode word");
    push(4, 32'h0, "R9 protection off");
    esc_strobe = 1'b1;
    push(4, 32'h0, "R8 no trap with flags clear");
    esc_strobe = 1'b0;

    wr(2'd0, 32'h4);
    esc_strobe = 1'b1;
    push(4, 32'h1, "R8 emulate traps");
    esc_strobe = 1'b0;

    wr(2'd0, 32'h0);
    task_switch = 1'b1;
    tick();
    task_switch = 1'b0;
    push(0, 32'h8, "R6 task switch sets flag");
    esc_strobe = 1'b1;
    push(4, 32'h1, "R7 task-switched traps");
    esc_strobe = 1'b0;
    push(4, 32'h0, "R7 no request without strobe");

    wr_en = 1'b1; wr_idx = 2'd0; wr_data = 32'h1; task_switch = 1'b1;
    tick();
    wr_en = 1'b0; task_switch = 1'b0;
    push(0, 32'h9, "R10 task switch beats write");
    wr(2'd0, 32'h1);
    push(0, 32'h1, "R10 software clears flag");

    wr(2'd1, 32'hFFFF_FFFF);
    push(1, 32'h0, "R3 reserved reads zero");
    push(0, 32'h1, "R3 write left slot 0");
    push(2, 32'h0, "R3 write left slot 2");
    push(3, 32'h0, "R3 write left slot 3");

    wr(2'd3, 32'h1234_5ABC);
    push(3, 32'h1234_5000, "R4 directory base aligned");
    wr(2'd3, 32'hFFFF_FFFF);
    push(3, 32'hFFFF_F000, "R4 all ones");

    fault_lin_addr = 32'hDEAD_BEEF; page_fault = 1'b1;
    tick();
    page_fault = 1'b0;
    push(2, 32'hDEAD_BEEF, "R5 fault capture");
    wr(2'd2, 32'h0000_0777);
    push(2, 32'h0000_0777, "R5 software write");
    wr_en = 1'b1; wr_idx = 2'd2; wr_data = 32'h111;
    fault_lin_addr = 32'h0000_5000; page_fault = 1'b1;
    tick();
    wr_en = 1'b0; page_fault = 1'b0;
    push(2, 32'h0000_5000, "R10 fault beats write");

    do_reset();
    check_all_zero("R1 reset after use");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule